// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Front End

This block sits beside a small 8-bit processor core and decides which interrupt the core takes next. It has five request inputs:

- one non-maskable emergency input;
- three vectored maskable inputs, named by their levels 7.5, 6.5 and 5.5;
- one general request that has no vector.

The block keeps three pieces of state: a software mask for each vectored maskable input, a global enable flip-flop, and an edge-capture flip-flop for the 7.5 input. The core pulses `sample_i` once per instruction. If no request is outstanding, the block then picks the highest-priority eligible source. It raises `req_valid_o` together with the source code and the 16-bit service address, and holds all three until the core pulses `ack_i`.

The core writes one control byte, which updates the masks, clears the 7.5 capture and drives the serial output bit. The core can read one status byte at any time. It shows the masks, the global enable, the pending inputs and the serial input pin. Separate pulses set and clear the global enable. When the core acknowledges the general request, the block answers with a one-cycle active-low acknowledge strobe.

Top module: `prio_irq_front`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block resets to this state: all three masks set, global enable clear, `req_valid_o` low, `inta_n_o` high and `ser_out_o` low.
- R2: On a clock edge with `sample_i` high and `req_valid_o` low, the block picks the first eligible source in the order emergency, 7.5, 6.5, 5.5, general. It raises `req_valid_o`, and `src_o` gives the winner as emergency=0, 7.5=1, 6.5=2, 5.5=3, general=4. If no source is eligible, nothing is raised.
- R3: `vec_o` holds the winner's service address: 0x0024 for emergency, 0x003C for 7.5, 0x0034 for 6.5 and 0x002C for 5.5. It holds 0x0000 for the general request.
- R4: Once raised, `req_valid_o`, `src_o` and `vec_o` stay unchanged until a clock edge with `ack_i` high, which drops `req_valid_o`. `sample_i` has no effect while a request is outstanding.
- R5: A control-byte write (`ctl_wr_i`) loads bits 2:0 into the masks for 5.5, 6.5 and 7.5 (bit 0 = 5.5), where 1 means masked. This happens only when bit 3 of the byte is 1; otherwise the masks are unchanged.
- R6: A control-byte write with bit 4 set clears the 7.5 capture flip-flop. A rising edge on the 7.5 pin at the same clock edge wins, and the capture stays set.
- R7: A control-byte write with bit 6 set loads bit 7 onto `ser_out_o`. With bit 6 clear, `ser_out_o` is kept. `ser_in_i` appears on status bit 7.
- R8: `status_o` bits 2:0 are the masks for 5.5, 6.5 and 7.5. Bit 3 is the global enable. Bits 4 and 5 are the live 5.5 and 6.5 pins. Bit 6 is the 7.5 capture flip-flop. Bit 7 is the serial input.
- R9: A rising edge on the 7.5 pin sets its capture flip-flop whatever the mask and enable state, so a one-cycle pulse is remembered. Acknowledging a 7.5 request clears the capture.
- R10: The 6.5 and 5.5 inputs are level-sensitive. Each is eligible only while its pin is high at the sampling edge, its mask is clear and the global enable is set. The general request needs only its pin and the global enable. 7.5 needs its capture, a clear mask and the global enable.
- R11: The emergency input ignores masks and the global enable. A rising edge arms it. It is eligible while armed and the pin is high. It disarms when the pin goes low or when its request is acknowledged, and it then needs a new rising edge.
- R12: `en_set_i` sets the global enable. `en_clr_i` clears it, and so does acknowledging any maskable source; a clear wins over a set at the same edge.
- R13: Acknowledging a general request drives `inta_n_o` low for exactly the one following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trap_i | input | 1 | Non-maskable emergency request |
| rq75_i | input | 1 | Edge-captured maskable request 7.5 |
| rq65_i | input | 1 | Level maskable request 6.5 |
| rq55_i | input | 1 | Level maskable request 5.5 |
| intr_i | input | 1 | General non-vectored request |
| ctl_wr_i | input | 1 | Control-byte write strobe |
| ctl_byte_i | input | 8 | Control byte |
| en_set_i | input | 1 | Global enable set pulse |
| en_clr_i | input | 1 | Global enable clear pulse |
| sample_i | input | 1 | Once-per-instruction sampling strobe |
| ack_i | input | 1 | Core acknowledge of the outstanding request |
| ser_in_i | input | 1 | Serial input pin |
| status_o | output | 8 | Status byte |
| ser_out_o | output | 1 | Serial output pin |
| req_valid_o | output | 1 | Request outstanding |
| src_o | output | 3 | Winning source code |
| vec_o | output | 16 | Service address |
| inta_n_o | output | 1 | Active-low general acknowledge |

## Verification
The bench goes after the following corner cases:

- **A one-cycle 7.5 pulse while masked.** A design that only looked at the live pin would lose the pulse.
- **A 7.5 rising edge at the same edge as a clear through bit 4.** A design that let the clear win would drop a fresh event.
- **An emergency input held high after its acknowledge.** A level-only design would re-enter service at every instruction.
- **A control write with bit 3 clear.** A design that ignored the gate would corrupt the masks.
- **Several sources at once, and samples taken while a request is outstanding.** Wrong priority, or a vector that moves before the acknowledge, shows up at once against the bench model.

// File: rtl/irqf_pkg.sv
// Shared types and constants for the interrupt front end.
// Assumes an 8-bit control/status byte and 16-bit service addresses.
package irqf_pkg;
    localparam int VEC_W  = 16;
    localparam int BYTE_W = 8;
    localparam int SRC_N  = 5;
    localparam int SRC_W  = $clog2(SRC_N);
    localparam int MSK_N  = 3;

    // Source codes; the lower the code, the higher the priority.
    typedef enum logic [SRC_W-1:0] {
        SRC_TRAP = 3'd0,
        SRC_R75  = 3'd1,
        SRC_R65  = 3'd2,
        SRC_R55  = 3'd3,
        SRC_GEN  = 3'd4
    } src_e;

    // Control-byte field positions.
    localparam int CB_MSE  = 3;
    localparam int CB_CLR7 = 4;
    localparam int CB_SOE  = 6;
    localparam int CB_SOD  = 7;

    localparam logic [VEC_W-1:0] VEC_TRAP = 16'h0024;
    localparam logic [VEC_W-1:0] VEC_R75  = 16'h003C;
    localparam logic [VEC_W-1:0] VEC_R65  = 16'h0034;
    localparam logic [VEC_W-1:0] VEC_R55  = 16'h002C;

    // Service address for a source; the general request has none.
    function automatic logic [VEC_W-1:0] vec_of(src_e s);
        case (s)
            SRC_TRAP: return VEC_TRAP;
            SRC_R75:  return VEC_R75;
            SRC_R65:  return VEC_R65;
            SRC_R55:  return VEC_R55;
            default:  return '0;
        endcase
    endfunction
endpackage

// File: rtl/irqf_edge_latch.sv
// Rising-edge capture flip-flop.
// A rising edge on pin_i sets flag_o; the set wins over clr_i.
// With HOLD_LEVEL=1 the flag also drops whenever the pin is low,
// giving an edge-and-level input.
module irqf_edge_latch #(
    parameter bit HOLD_LEVEL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    input  logic clr_i,
    output logic flag_o
);
    logic pin_q;
    logic rise;
    logic drop;

    assign rise = pin_i & ~pin_q;

    generate
        if (HOLD_LEVEL) begin : g_hold
            assign drop = clr_i | ~pin_i;
        end else begin : g_edge
            assign drop = clr_i;
        end
    endgenerate

    // Remember the pin and update the capture flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin_q  <= 1'b0;
            flag_o <= 1'b0;
        end else begin
            pin_q <= pin_i;
            if (rise)
                flag_o <= 1'b1;
            else if (drop)
                flag_o <= 1'b0;
        end
    end
endmodule

// File: rtl/irqf_mask_regs.sv
// Software-visible state: the mask bits, the global enable and the serial-out bit.
// Assumes ctl_wr_i is a single-cycle strobe with ctl_byte_i valid in that cycle.
module irqf_mask_regs
    import irqf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_wr_i,
    input  logic [BYTE_W-1:0] ctl_byte_i,
    input  logic              en_set_i,
    input  logic              en_clr_i,
    input  logic              take_mask_i,
    output logic [MSK_N-1:0]  masks_o,
    output logic              ie_o,
    output logic              sod_o,
    output logic              clr75_o
);
    assign clr75_o = ctl_wr_i & ctl_byte_i[CB_CLR7];

    // Gated mask load and serial-output load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            masks_o <= '1;
            sod_o   <= 1'b0;
        end else if (ctl_wr_i) begin
            if (ctl_byte_i[CB_MSE])
                masks_o <= ctl_byte_i[MSK_N-1:0];
            if (ctl_byte_i[CB_SOE])
                sod_o <= ctl_byte_i[CB_SOD];
        end
    end

    // Global enable; any clear wins over a set.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ie_o <= 1'b0;
        else if (en_clr_i || take_mask_i)
            ie_o <= 1'b0;
        else if (en_set_i)
            ie_o <= 1'b1;
    end
endmodule

// File: rtl/irqf_pick.sv
// Fixed-priority selection among the eligible sources.
// Purely combinational; the lowest set index of the eligibility vector wins.
module irqf_pick
    import irqf_pkg::*;
(
    input  logic             trap_arm_i,
    input  logic             trap_pin_i,
    input  logic             cap75_i,
    input  logic             pin65_i,
    input  logic             pin55_i,
    input  logic             gen_i,
    input  logic [MSK_N-1:0] masks_i,
    input  logic             ie_i,
    output logic             any_o,
    output src_e             win_o
);
    logic [SRC_N-1:0] elig;

    // Build the per-source eligibility vector.
    always_comb begin
        elig           = '0;
        elig[SRC_TRAP] = trap_arm_i & trap_pin_i;
        elig[SRC_R75]  = cap75_i & ~masks_i[2] & ie_i;
        elig[SRC_R65]  = pin65_i & ~masks_i[1] & ie_i;
        elig[SRC_R55]  = pin55_i & ~masks_i[0] & ie_i;
        elig[SRC_GEN]  = gen_i & ie_i;
    end

    // Scan from lowest to highest priority so the highest one remains.
    always_comb begin
        any_o = |elig;
        win_o = SRC_GEN;
        for (int i = SRC_N - 1; i >= 0; i--) begin
            if (elig[i])
                win_o = src_e'(SRC_W'(i));
        end
    end
endmodule

// File: rtl/prio_irq_front.sv
// Interrupt front end: captures the requests, resolves priority at each sample
// strobe and holds the winner until the core acknowledges it.
// Assumes sample_i and ack_i are single-cycle pulses from the core.
module prio_irq_front
    import irqf_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        trap_i,
    input  logic        rq75_i,
    input  logic        rq65_i,
    input  logic        rq55_i,
    input  logic        intr_i,
    input  logic        ctl_wr_i,
    input  logic [7:0]  ctl_byte_i,
    input  logic        en_set_i,
    input  logic        en_clr_i,
    input  logic        sample_i,
    input  logic        ack_i,
    input  logic        ser_in_i,
    output logic [7:0]  status_o,
    output logic        ser_out_o,
    output logic        req_valid_o,
    output logic [2:0]  src_o,
    output logic [15:0] vec_o,
    output logic        inta_n_o
);
    logic             valid_q;
    src_e             src_q;
    logic [VEC_W-1:0] vec_q;
    logic             inta_n_q;
    logic             take;
    logic             take_mask;
    logic             trap_arm;
    logic             cap75;
    logic             clr75_sw;
    logic [MSK_N-1:0] masks;
    logic             ie;
    logic             any;
    src_e             win;

    assign take      = valid_q & ack_i;
    assign take_mask = take & (src_q != SRC_TRAP);

    irqf_edge_latch #(.HOLD_LEVEL(1'b1)) u_trap (
        .clk(clk), .rst_n(rst_n), .pin_i(trap_i),
        .clr_i(take && src_q == SRC_TRAP), .flag_o(trap_arm)
    );

    irqf_edge_latch #(.HOLD_LEVEL(1'b0)) u_cap75 (
        .clk(clk), .rst_n(rst_n), .pin_i(rq75_i),
        .clr_i((take && src_q == SRC_R75) || clr75_sw), .flag_o(cap75)
    );

    irqf_mask_regs u_regs (
        .clk(clk), .rst_n(rst_n), .ctl_wr_i(ctl_wr_i), .ctl_byte_i(ctl_byte_i),
        .en_set_i(en_set_i), .en_clr_i(en_clr_i), .take_mask_i(take_mask),
        .masks_o(masks), .ie_o(ie), .sod_o(ser_out_o), .clr75_o(clr75_sw)
    );

    irqf_pick u_pick (
        .trap_arm_i(trap_arm), .trap_pin_i(trap_i), .cap75_i(cap75),
        .pin65_i(rq65_i), .pin55_i(rq55_i), .gen_i(intr_i),
        .masks_i(masks), .ie_i(ie), .any_o(any), .win_o(win)
    );

    // Outstanding-request register: load on a sample, release on acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q  <= 1'b0;
            src_q    <= SRC_TRAP;
            vec_q    <= '0;
            inta_n_q <= 1'b1;
        end else begin
            inta_n_q <= !(take && src_q == SRC_GEN);
            if (take) begin
                valid_q <= 1'b0;
            end else if (!valid_q && sample_i && any) begin
                valid_q <= 1'b1;
                src_q   <= win;
                vec_q   <= vec_of(win);
            end
        end
    end

    assign status_o    = {ser_in_i, cap75, rq65_i, rq55_i, ie, masks};
    assign req_valid_o = valid_q;
    assign src_o       = src_q;
    assign vec_o       = vec_q;
    assign inta_n_o    = inta_n_q;
endmodule

// File: rtl/prio_irq_front_chk.sv
// Temporal checks on the interrupt front end, attached by bind.
module prio_irq_front_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        rq75_i,
    input logic        ctl_wr_i,
    input logic [7:0]  ctl_byte_i,
    input logic        ack_i,
    input logic [7:0]  status_o,
    input logic        req_valid_o,
    input logic [2:0]  src_o,
    input logic [15:0] vec_o,
    input logic        inta_n_o
);
    assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_o && !ack_i |=> req_valid_o && $stable(src_o) && $stable(vec_o));

    assert_ie_drop_R12: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_o && ack_i && src_o != 3'd0 |=> !status_o[3]);

    assert_mask_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr_i && !ctl_byte_i[3] |=> $stable(status_o[2:0]));

    assert_capture_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rq75_i) |=> status_o[6]);

    assert_sw_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr_i && ctl_byte_i[4] && !$rose(rq75_i) |=> !status_o[6]);

    assert_inta_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !inta_n_o |-> $past(req_valid_o && ack_i && src_o == 3'd4));

    assert_trap_vec_R3: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_o && src_o == 3'd0 |-> vec_o == 16'h0024);
endmodule

bind prio_irq_front prio_irq_front_chk chk_i (
    .clk(clk), .rst_n(rst_n), .rq75_i(rq75_i), .ctl_wr_i(ctl_wr_i),
    .ctl_byte_i(ctl_byte_i), .ack_i(ack_i), .status_o(status_o),
    .req_valid_o(req_valid_o), .src_o(src_o), .vec_o(vec_o), .inta_n_o(inta_n_o)
);

// File: tb/prio_irq_front_tb_top.sv
`timescale 1ns/1ps
module prio_irq_front_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic trap = 0, r75 = 0, r65 = 0, r55 = 0, intr = 0;
    logic mw = 0, es = 0, ec = 0, smp = 0, ack = 0, sin = 0;
    logic [7:0]  mb = 0;
    logic [7:0]  status;
    logic        sod, valid, inta_n;
    logic [2:0]  src;
    logic [15:0] vec;

    int n_tests = 0;
    int n_fail  = 0;

    // Reference model state.
    logic [2:0] m_masks;
    logic m_ie, m_cap75, m_r75q, m_trapq, m_arm, m_sod, m_valid, m_inta_n;
    logic [2:0] m_src;

    always #4 clk = ~clk;

    prio_irq_front dut_i (
        .clk(clk), .rst_n(rst_n), .trap_i(trap), .rq75_i(r75), .rq65_i(r65),
        .rq55_i(r55), .intr_i(intr), .ctl_wr_i(mw), .ctl_byte_i(mb),
        .en_set_i(es), .en_clr_i(ec), .sample_i(smp), .ack_i(ack),
        .ser_in_i(sin), .status_o(status), .ser_out_o(sod), .req_valid_o(valid),
        .src_o(src), .vec_o(vec), .inta_n_o(inta_n)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
        end
    endtask

    function automatic logic [15:0] exp_vec(input logic [2:0] s);
        case (s)
            3'd0: return 16'h0024;
            3'd1: return 16'h003C;
            3'd2: return 16'h0034;
            3'd3: return 16'h002C;
            default: return 16'h0000;
        endcase
    endfunction

    // Winner by the stated priority order; 3'd7 means none eligible.
    function automatic logic [2:0] exp_pick();
        if (m_arm && trap)                return 3'd0;
        if (m_cap75 && !m_masks[2] && m_ie) return 3'd1;
        if (r65 && !m_masks[1] && m_ie)     return 3'd2;
        if (r55 && !m_masks[0] && m_ie)     return 3'd3;
        if (intr && m_ie)                   return 3'd4;
        return 3'd7;
    endfunction

    task automatic compare_all();
        chk("R4 valid", valid, m_valid);
        if (m_valid) begin
            chk("R2 src", src, m_src);
            chk("R3 vec", vec, exp_vec(m_src));
        end
        chk("R5 masks", status[2:0], m_masks);
        chk("R12 enable", status[3], m_ie);
        chk("R10 level pins", status[5:4], {r65, r55});
        chk("R9 capture", status[6], m_cap75);
        chk("R8 serial in", status[7], sin);
        chk("R7 serial out", sod, m_sod);
        chk("R13 inta", inta_n, m_inta_n);
    endtask

    // One clock: compute the model's next state, step, then compare off-edge.
    task automatic tick();
        logic take, n_arm, n_cap, n_ie, n_valid, n_inta;
        logic [2:0] n_masks, n_src, w;
        logic n_sod;
        if (!rst_n) begin
            n_masks = 3'b111; n_ie = 0; n_cap = 0; n_arm = 0; n_sod = 0;
            n_valid = 0; n_src = 0; n_inta = 1;
        end else begin
            take  = m_valid && ack;
            n_arm = (trap && !m_trapq) ? 1'b1 : ((!trap || (take && m_src == 0)) ? 1'b0 : m_arm);
            n_cap = (r75 && !m_r75q) ? 1'b1 :
                    (((take && m_src == 1) || (mw && mb[4])) ? 1'b0 : m_cap75);
            n_masks = (mw && mb[3]) ? mb[2:0] : m_masks;
            n_sod   = (mw && mb[6]) ? mb[7] : m_sod;
            n_ie    = (ec || (take && m_src != 0)) ? 1'b0 : (es ? 1'b1 : m_ie);
            n_inta  = !(take && m_src == 4);
            n_valid = m_valid;
            n_src   = m_src;
            w       = exp_pick();
            if (take) n_valid = 0;
            else if (!m_valid && smp && w != 3'd7) begin
                n_valid = 1;
                n_src   = w;
            end
        end
        @(posedge clk);
        #1;
        m_masks = n_masks; m_ie = n_ie; m_cap75 = n_cap; m_arm = n_arm; m_sod = n_sod;
        m_valid = n_valid; m_src = n_src; m_inta_n = n_inta;
        m_r75q  = rst_n ? r75 : 1'b0;
        m_trapq = rst_n ? trap : 1'b0;
        @(negedge clk);
        compare_all();
    endtask

    task automatic pulses_off();
        mw = 0; es = 0; ec = 0; smp = 0; ack = 0; mb = 0;
    endtask

    // Watchdog: an expired run counts as a failure and still reports.
    initial begin
        #(8 * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        @(negedge clk);
        tick(); tick();
        rst_n = 1;
        @(negedge clk);
        // R1: reset state with all pins low.
        chk("R1 status", status, 8'h07);
        chk("R1 valid", valid, 1'b0);
        chk("R1 inta", inta_n, 1'b1);
        chk("R1 sod", sod, 1'b0);

        // R5: a write with bit 3 clear leaves the masks; then unmask all.
        mw = 1; mb = 8'h00; tick(); pulses_off();
        chk("R5 gated write", status[2:0], 3'b111);
        mw = 1; mb = 8'h08; tick(); pulses_off();
        chk("R5 unmask", status[2:0], 3'b000);

        // R12: enable.
        es = 1; tick(); pulses_off();
        chk("R12 set", status[3], 1'b1);

        // R9 / R2 / R3: a short 7.5 pulse beats the pending 6.5, 5.5 and general requests.
        r65 = 1; r55 = 1; intr = 1; r75 = 1; tick(); r75 = 0;
        smp = 1; tick(); pulses_off();
        chk("R2 7.5 wins", {valid, src}, {1'b1, 3'd1});
        chk("R3 7.5 vec", vec, 16'h003C);
        smp = 1; tick(); tick(); pulses_off();
        chk("R4 held", {valid, src}, {1'b1, 3'd1});
        ack = 1; tick(); pulses_off();
        chk("R9 ack clears capture", status[6], 1'b0);
        chk("R12 ack clears enable", status[3], 1'b0);

        // R10 / R12: disabled, so the level requests are not taken.
        smp = 1; tick(); pulses_off();
        chk("R12 disabled no take", valid, 1'b0);
        r65 = 0; r55 = 0; intr = 0;

        // R11: the emergency input works while disabled, then needs a new edge.
        trap = 1; tick();
        smp = 1; tick(); pulses_off();
        chk("R11 trap taken", {valid, src}, {1'b1, 3'd0});
        chk("R3 trap vec", vec, 16'h0024);
        ack = 1; tick(); pulses_off();
        smp = 1; tick(); pulses_off();
        chk("R11 held high no retake", valid, 1'b0);
        trap = 0; tick(); trap = 1; tick();
        smp = 1; tick(); pulses_off();
        chk("R11 retake after edge", {valid, src}, {1'b1, 3'd0});
        ack = 1; tick(); pulses_off();
        trap = 0; tick();

        // R6: a rising edge beats a coincident clear; a lone clear works.
        r75 = 1; mw = 1; mb = 8'h10; tick(); pulses_off();
        chk("R6 edge wins", status[6], 1'b1);
        r75 = 0; mw = 1; mb = 8'h10; tick(); pulses_off();
        chk("R6 clear", status[6], 1'b0);

        // R7: serial out loads only with bit 6; serial in shows on bit 7.
        mw = 1; mb = 8'hC0; tick(); pulses_off();
        chk("R7 sod set", sod, 1'b1);
        mw = 1; mb = 8'h80; tick(); pulses_off();
        chk("R7 sod kept", sod, 1'b1);
        mw = 1; mb = 8'h40; tick(); pulses_off();
        chk("R7 sod cleared", sod, 1'b0);
        sin = 1; tick();
        chk("R8 sin bit", status[7], 1'b1);
        sin = 0;

        // R13: general request, acknowledge strobe for exactly one cycle.
        es = 1; tick(); pulses_off();
        intr = 1; smp = 1; tick(); pulses_off();
        chk("R2 general", {valid, src}, {1'b1, 3'd4});
        chk("R3 general vec", vec, 16'h0000);
        ack = 1; tick(); pulses_off(); intr = 0;
        chk("R13 low", inta_n, 1'b0);
        tick();
        chk("R13 one cycle", inta_n, 1'b1);

        // R10: a masked 5.5 is skipped; once unmasked it is taken.
        es = 1; mw = 1; mb = 8'h09; tick(); pulses_off();
        r55 = 1; smp = 1; tick(); pulses_off();
        chk("R10 masked 5.5", valid, 1'b0);
        mw = 1; mb = 8'h08; tick(); pulses_off();
        smp = 1; tick(); pulses_off();
        chk("R10 5.5 taken", {valid, src}, {1'b1, 3'd3});
        chk("R3 5.5 vec", vec, 16'h002C);
        ack = 1; tick(); pulses_off(); r55 = 0;

        // Constrained random phase, checked every cycle against the model.
        for (int i = 0; i < 20000; i++) begin
            if ($urandom % 60 == 0) trap = ~trap;
            if ($urandom % 6 == 0)  r75  = ~r75;
            if ($urandom % 8 == 0)  r65  = ~r65;
            if ($urandom % 8 == 0)  r55  = ~r55;
            if ($urandom % 8 == 0)  intr = ~intr;
            if ($urandom % 10 == 0) sin  = ~sin;
            mw  = ($urandom % 12 == 0);
            mb  = 8'($urandom);
            es  = ($urandom % 5 == 0);
            ec  = ($urandom % 30 == 0);
            smp = ($urandom % 3 == 0);
            ack = ($urandom % 4 == 0);
            tick();
        end
        pulses_off();

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule